// File: doc/BRIEF.md
# Bridge System-Error Reporter

This block decides when a two-port bus bridge pulls its active-low upstream system-error line. It watches four configuration enables, the system-error line coming up from the downstream bus, and a single event strobe from the transaction engines. Each strobe is tagged with an event kind, a transfer type, a direction and the bus on which the condition was seen. A cause is one of the following: a forwarded downstream system error, a qualified parity error on a posted write, an abort on a posted write, or a write that is dropped after too many retries. Any cause, gated by the global system-error enable, drives the output low for the following clock. The same edge updates two sticky status bits, and software clears them by writing one.

A single retry counter follows the write transaction that is currently in flight. Each target-retry event on a posted or delayed write increments it. When the counter is already at its maximum value, the next retry drops the write. The counter returns to zero when the transaction completes or is dropped. The counter width is a parameter: 24 bits in a chip, and a few bits in a test.

Top module: `bridge_serr_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pri_serr_n` is 1 and `sts_sig_serr`, `sts_rcv_serr` and `wr_discard` are 0.
- R2: `pri_serr_n` goes low only in the cycle after one in which `cmd_serr_en` was 1. When that enable is 0, `sts_sig_serr` is not set, and `wr_discard` still pulses.
- R3: If `sec_serr_n` is 0 and `bctl_serr_fwd_en` is 1 at a clock edge, `sts_rcv_serr` is 1 after that edge, and `pri_serr_n` is 0 for the next cycle when `cmd_serr_en` is 1. If `bctl_serr_fwd_en` is 0, the input has no effect.
- R4: A parity event (`ev_kind`=0) on a posted write (`ev_xfer`=1) is a cause only when `ev_bus` names the target bus and `ev_tgt_seen` is 0. The target bus is primary (`ev_bus`=0) for an upstream transfer (`ev_dir`=1) and secondary (`ev_bus`=1) for a downstream transfer (`ev_dir`=0).
- R5: A posted-write parity event is a cause only when both `cmd_perr_resp` and `bctl_perr_resp` are 1.
- R6: Parity events on reads (`ev_xfer`=0) and on delayed writes (`ev_xfer`=2) never cause an assertion.
- R7: A target abort (`ev_kind`=1) or a master abort (`ev_kind`=2) is a cause on a posted write only. On other transfer types it has no effect.
- R8: With counter width W, the 2^W-th retry event (`ev_kind`=3) on a write (`ev_xfer` 1 or 2) with no completion in between drops the write. `wr_discard` is then 1 for one cycle, and the drop is a cause. Retries on reads are not counted.
- R9: A completion event (`ev_kind`=4) returns the retry count to zero.
- R10: Whenever `pri_serr_n` is 0, `sts_sig_serr` is 1.
- R11: Status bits are sticky. `clr_sig_serr` and `clr_rcv_serr` clear them, and a set in the same cycle as a clear wins.
- R12: Each cause holds `pri_serr_n` low for exactly one cycle. The line returns high in the next cycle unless a new cause is present. Strobe fields are ignored while `ev_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_serr_en | input | 1 | Global system-error enable |
| cmd_perr_resp | input | 1 | Parity-response enable, command side |
| bctl_perr_resp | input | 1 | Parity-response enable, bridge-control side |
| bctl_serr_fwd_en | input | 1 | Forward downstream system error |
| sec_serr_n | input | 1 | Downstream system-error input, active low |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | 0 parity, 1 target abort, 2 master abort, 3 retry, 4 completion |
| ev_xfer | input | 2 | 0 read, 1 posted write, 2 delayed write |
| ev_dir | input | 1 | 0 downstream, 1 upstream |
| ev_bus | input | 1 | Detecting bus: 0 primary, 1 secondary |
| ev_tgt_seen | input | 1 | Bridge saw the parity error itself as target |
| clr_sig_serr | input | 1 | Write-one-to-clear for the signaled bit |
| clr_rcv_serr | input | 1 | Write-one-to-clear for the received bit |
| pri_serr_n | output | 1 | Upstream system-error output, active low |
| sts_sig_serr | output | 1 | Sticky: system error signaled |
| sts_rcv_serr | output | 1 | Sticky: downstream system error received |
| wr_discard | output | 1 | One-cycle pulse when a write is dropped |

## Verification
The bench builds the block with a retry counter width of 3, so a write is dropped on its eighth retry. With that width, the drop limit, the counter reset on completion and the restart count after a drop can each be reached in a handful of cycles, where the chip setting would need millions. All other parameters keep their defaults, because the reporting logic does not depend on the counter width.

// File: rtl/bserr_pkg.sv
package bserr_pkg;

    typedef enum logic [2:0] {
        EV_PERR   = 3'd0,
        EV_TABORT = 3'd1,
        EV_MABORT = 3'd2,
        EV_RETRY  = 3'd3,
        EV_DONE   = 3'd4
    } ev_kind_e;

    typedef enum logic [1:0] {
        XF_READ    = 2'd0,
        XF_POSTED  = 2'd1,
        XF_DELAYED = 2'd2
    } xfer_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic {
        BUS_PRI = 1'b0,
        BUS_SEC = 1'b1
    } bus_e;

    typedef struct packed {
        logic     valid;
        ev_kind_e kind;
        xfer_e    xfer;
        dir_e     dir;
        bus_e     bus;
        logic     tgt_seen;
    } txn_ev_t;

    typedef struct packed {
        logic serr_en;
        logic cmd_perr;
        logic bctl_perr;
        logic fwd_en;
    } serr_cfg_t;

    typedef struct packed {
        logic fwd;
        logic parity;
        logic abort;
        logic drop;
    } cause_t;

    localparam int NUM_STS = 2;
    localparam int STS_SIG = 0;
    localparam int STS_RCV = 1;

    function automatic bus_e target_bus(dir_e d);
        return (d == DIR_UP) ? BUS_PRI : BUS_SEC;
    endfunction

    function automatic logic is_write(xfer_e x);
        return (x == XF_POSTED) || (x == XF_DELAYED);
    endfunction

endpackage

// File: rtl/bserr_retry_track.sv
module bserr_retry_track
    import bserr_pkg::*;
#(
    parameter int RETRY_W = 24
) (
    input  logic    clk,
    input  logic    rst,
    input  txn_ev_t ev,
    output logic    drop
);
    localparam logic [RETRY_W-1:0] CNT_LAST = '1;

    logic [RETRY_W-1:0] cnt_q;
    logic               retry_hit;
    logic               done_hit;

    assign retry_hit = ev.valid && (ev.kind == EV_RETRY) && is_write(ev.xfer);
    assign done_hit  = ev.valid && (ev.kind == EV_DONE);
    assign drop      = retry_hit && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (done_hit || drop) begin
            cnt_q <= '0;
        end else if (retry_hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bserr_cause_dec.sv
module bserr_cause_dec
    import bserr_pkg::*;
(
    input  serr_cfg_t cfg,
    input  txn_ev_t   ev,
    input  logic      sec_serr_n,
    input  logic      drop,
    output cause_t    cause,
    output logic      rcv_set
);
    logic posted;

    assign posted = ev.valid && (ev.xfer == XF_POSTED);

    always_comb begin
        rcv_set      = !sec_serr_n && cfg.fwd_en;
        cause.fwd    = rcv_set;
        cause.parity = posted && (ev.kind == EV_PERR)
                       && (ev.bus == target_bus(ev.dir))
                       && !ev.tgt_seen
                       && cfg.cmd_perr && cfg.bctl_perr;
        cause.abort  = posted && ((ev.kind == EV_TABORT) || (ev.kind == EV_MABORT));
        cause.drop   = drop;
    end
endmodule

// File: rtl/bserr_status.sv
module bserr_status #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] set,
    input  logic [NBITS-1:0] clr,
    output logic [NBITS-1:0] q
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bridge_serr_ctrl.sv
module bridge_serr_ctrl
    import bserr_pkg::*;
#(
    parameter int RETRY_W = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_serr_en,
    input  logic       cmd_perr_resp,
    input  logic       bctl_perr_resp,
    input  logic       bctl_serr_fwd_en,
    input  logic       sec_serr_n,
    input  logic       ev_valid,
    input  logic [2:0] ev_kind,
    input  logic [1:0] ev_xfer,
    input  logic       ev_dir,
    input  logic       ev_bus,
    input  logic       ev_tgt_seen,
    input  logic       clr_sig_serr,
    input  logic       clr_rcv_serr,
    output logic       pri_serr_n,
    output logic       sts_sig_serr,
    output logic       sts_rcv_serr,
    output logic       wr_discard
);
    txn_ev_t            ev;
    serr_cfg_t          cfg;
    cause_t             cause;
    logic               drop;
    logic               rcv_set;
    logic               serr_d;
    logic               serr_q;
    logic               drop_q;
    logic [NUM_STS-1:0] sts_set;
    logic [NUM_STS-1:0] sts_clr;
    logic [NUM_STS-1:0] sts_q;

    always_comb begin
        ev.valid    = ev_valid;
        ev.kind     = ev_kind_e'(ev_kind);
        ev.xfer     = xfer_e'(ev_xfer);
        ev.dir      = dir_e'(ev_dir);
        ev.bus      = bus_e'(ev_bus);
        ev.tgt_seen = ev_tgt_seen;
        cfg.serr_en   = cmd_serr_en;
        cfg.cmd_perr  = cmd_perr_resp;
        cfg.bctl_perr = bctl_perr_resp;
        cfg.fwd_en    = bctl_serr_fwd_en;
    end

    bserr_retry_track #(.RETRY_W(RETRY_W)) u_retry (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .drop (drop)
    );

    bserr_cause_dec u_dec (
        .cfg        (cfg),
        .ev         (ev),
        .sec_serr_n (sec_serr_n),
        .drop       (drop),
        .cause      (cause),
        .rcv_set    (rcv_set)
    );

    assign serr_d = cfg.serr_en && (|cause);

    always_ff @(posedge clk) begin
        if (rst) begin
            serr_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            serr_q <= serr_d;
            drop_q <= drop;
        end
    end

    always_comb begin
        sts_set          = '0;
        sts_clr          = '0;
        sts_set[STS_SIG] = serr_d;
        sts_set[STS_RCV] = rcv_set;
        sts_clr[STS_SIG] = clr_sig_serr;
        sts_clr[STS_RCV] = clr_rcv_serr;
    end

    bserr_status #(.NBITS(NUM_STS)) u_sts (
        .clk (clk),
        .rst (rst),
        .set (sts_set),
        .clr (sts_clr),
        .q   (sts_q)
    );

    assign pri_serr_n   = !serr_q;
    assign wr_discard   = drop_q;
    assign sts_sig_serr = sts_q[STS_SIG];
    assign sts_rcv_serr = sts_q[STS_RCV];
endmodule

// File: rtl/bserr_chk.sv
module bserr_chk (
    input logic clk,
    input logic rst,
    input logic cmd_serr_en,
    input logic bctl_serr_fwd_en,
    input logic sec_serr_n,
    input logic clr_sig_serr,
    input logic pri_serr_n,
    input logic sts_sig_serr,
    input logic sts_rcv_serr,
    input logic wr_discard
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pri_serr_n && !sts_sig_serr && !sts_rcv_serr && !wr_discard));

    // R2
    gated_by_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !pri_serr_n |-> $past(cmd_serr_en));

    // R10
    sig_tracks_out_chk: assert property (@(posedge clk) disable iff (rst)
        !pri_serr_n |-> sts_sig_serr);

    // R3
    fwd_sets_rcv_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !sec_serr_n && bctl_serr_fwd_en) |-> sts_rcv_serr);

    // R8
    drop_reports_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_discard && $past(cmd_serr_en)) |-> !pri_serr_n);

    // R11
    sig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sts_sig_serr && !clr_sig_serr) |-> sts_sig_serr);
endmodule

bind bridge_serr_ctrl bserr_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .cmd_serr_en      (cmd_serr_en),
    .bctl_serr_fwd_en (bctl_serr_fwd_en),
    .sec_serr_n       (sec_serr_n),
    .clr_sig_serr     (clr_sig_serr),
    .pri_serr_n       (pri_serr_n),
    .sts_sig_serr     (sts_sig_serr),
    .sts_rcv_serr     (sts_rcv_serr),
    .wr_discard       (wr_discard)
);

// File: tb/tb_bridge_serr_ctrl.sv
`timescale 1ns/1ps
module tb_bridge_serr_ctrl;
    import bserr_pkg::*;

    localparam int RW = 3;
    localparam int LIMIT = 1 << RW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_serr_en = 0, cmd_perr_resp = 0, bctl_perr_resp = 0, bctl_serr_fwd_en = 0;
    logic sec_serr_n = 1;
    logic ev_valid = 0;
    logic [2:0] ev_kind = 0;
    logic [1:0] ev_xfer = 0;
    logic ev_dir = 0, ev_bus = 0, ev_tgt_seen = 0;
    logic clr_sig_serr = 0, clr_rcv_serr = 0;
    logic pri_serr_n, sts_sig_serr, sts_rcv_serr, wr_discard;

    logic c_serr = 1, c_cperr = 1, c_bperr = 1, c_fwd = 1;
    logic m_sig = 0, m_rcv = 0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic  serr_n;
        logic  disc;
        logic  sig;
        logic  rcv;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t it;

    always #4 clk = ~clk;

    bridge_serr_ctrl #(.RETRY_W(RW)) dut (
        .clk(clk), .rst(rst),
        .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp),
        .bctl_perr_resp(bctl_perr_resp), .bctl_serr_fwd_en(bctl_serr_fwd_en),
        .sec_serr_n(sec_serr_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_xfer(ev_xfer), .ev_dir(ev_dir), .ev_bus(ev_bus),
        .ev_tgt_seen(ev_tgt_seen), .clr_sig_serr(clr_sig_serr),
        .clr_rcv_serr(clr_rcv_serr), .pri_serr_n(pri_serr_n),
        .sts_sig_serr(sts_sig_serr), .sts_rcv_serr(sts_rcv_serr),
        .wr_discard(wr_discard)
    );

    // driver: one call per cycle, pushes what the next edge must produce
    task automatic cyc(input logic v, input logic [2:0] k, input logic [1:0] x,
                       input logic d, input logic b, input logic t,
                       input logic secn, input logic csig, input logic crcv,
                       input logic e_ser, input logic e_dis, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_serr_en = c_serr; cmd_perr_resp = c_cperr;
        bctl_perr_resp = c_bperr; bctl_serr_fwd_en = c_fwd;
        ev_valid = v; ev_kind = k; ev_xfer = x; ev_dir = d; ev_bus = b;
        ev_tgt_seen = t; sec_serr_n = secn;
        clr_sig_serr = csig; clr_rcv_serr = crcv;
        if (!secn && c_fwd) m_rcv = 1'b1; else if (crcv) m_rcv = 1'b0;
        if (e_ser) m_sig = 1'b1; else if (csig) m_sig = 1'b0;
        e.serr_n = !e_ser; e.disc = e_dis; e.sig = m_sig; e.rcv = m_rcv; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic ev(input logic [2:0] k, input logic [1:0] x, input logic d,
                      input logic b, input logic t, input logic e_ser,
                      input logic e_dis, input string tag);
        cyc(1'b1, k, x, d, b, t, 1'b1, 1'b0, 1'b0, e_ser, e_dis, tag);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor: compares one item shortly after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (pri_serr_n !== it.serr_n || wr_discard !== it.disc ||
                sts_sig_serr !== it.sig || sts_rcv_serr !== it.rcv) begin
                fails++;
                $display("FAIL %s: got serr_n=%b disc=%b sig=%b rcv=%b exp serr_n=%b disc=%b sig=%b rcv=%b",
                         it.tag, pri_serr_n, wr_discard, sts_sig_serr, sts_rcv_serr,
                         it.serr_n, it.disc, it.sig, it.rcv);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (pri_serr_n !== 1'b1 || sts_sig_serr !== 1'b0 || sts_rcv_serr !== 1'b0 || wr_discard !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got serr_n=%b sig=%b rcv=%b disc=%b exp 1 0 0 0",
                     pri_serr_n, sts_sig_serr, sts_rcv_serr, wr_discard);
        end
        rst = 1'b0;
        idle("R1 after reset");

        // R3 forwarding, R10 signaled bit, R12 single cycle
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 forward");
        idle("R12 release after forward");
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R11 clear both");

        // R4 posted parity qualification
        ev(EV_PERR, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b1, 1'b0, "R4 down on secondary");
        ev(EV_PERR, XF_POSTED, DIR_DOWN, BUS_PRI, 1'b0, 1'b0, 1'b0, "R4 down on primary");
        ev(EV_PERR, XF_POSTED, DIR_UP,   BUS_PRI, 1'b1, 1'b0, 1'b0, "R4 seen as target");
        ev(EV_PERR, XF_POSTED, DIR_UP,   BUS_PRI, 1'b0, 1'b1, 1'b0, "R4 up on primary");
        ev(EV_PERR, XF_POSTED, DIR_UP,   BUS_SEC, 1'b0, 1'b0, 1'b0, "R4 up on secondary");
        // R12 strobe fields ignored while not valid
        cyc(1'b0, EV_PERR, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R12 invalid strobe");

        // R6 reads and delayed writes
        ev(EV_PERR, XF_READ,    DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R6 read parity");
        ev(EV_PERR, XF_DELAYED, DIR_UP,   BUS_PRI, 1'b0, 1'b0, 1'b0, "R6 delayed parity");

        // R5 both parity responses needed
        c_cperr = 1'b0;
        ev(EV_PERR, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R5 command response off");
        c_cperr = 1'b1; c_bperr = 1'b0;
        ev(EV_PERR, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R5 control response off");
        c_bperr = 1'b1;

        // R7 aborts
        ev(EV_TABORT, XF_POSTED,  DIR_DOWN, BUS_SEC, 1'b0, 1'b1, 1'b0, "R7 target abort posted");
        ev(EV_MABORT, XF_POSTED,  DIR_UP,   BUS_PRI, 1'b0, 1'b1, 1'b0, "R7 master abort posted");
        ev(EV_TABORT, XF_DELAYED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R7 abort delayed");
        ev(EV_MABORT, XF_READ,    DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R7 abort read");

        // R11 set wins over clear
        cyc(1'b1, EV_TABORT, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R11 set wins");
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 clear signaled");

        // R8 drop at limit
        for (int i = 1; i < LIMIT; i++)
            ev(EV_RETRY, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R8 retry below limit");
        ev(EV_RETRY, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b1, 1'b1, "R8 retry at limit");
        ev(EV_RETRY, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R8 count restarts");

        // R9 completion resets the count
        ev(EV_DONE, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R9 completion");
        for (int i = 0; i < 5; i++)
            ev(EV_RETRY, XF_DELAYED, DIR_UP, BUS_PRI, 1'b0, 1'b0, 1'b0, "R9 partial retries");
        ev(EV_DONE, XF_DELAYED, DIR_UP, BUS_PRI, 1'b0, 1'b0, 1'b0, "R9 completion again");
        for (int i = 1; i < LIMIT; i++)
            ev(EV_RETRY, XF_DELAYED, DIR_UP, BUS_PRI, 1'b0, 1'b0, 1'b0, "R9 full count after reset");
        ev(EV_RETRY, XF_DELAYED, DIR_UP, BUS_PRI, 1'b0, 1'b1, 1'b1, "R8 delayed write drop");

        // R8 reads are not counted
        ev(EV_DONE, XF_READ, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R9 completion read");
        for (int i = 0; i < LIMIT + 2; i++)
            ev(EV_RETRY, XF_READ, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R8 read retries");

        // R2 global enable off
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R11 clear before R2");
        c_serr = 1'b0;
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 forward gated");
        ev(EV_TABORT, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R2 abort gated");
        ev(EV_DONE, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R2 completion");
        for (int i = 1; i < LIMIT; i++)
            ev(EV_RETRY, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b0, "R2 retries");
        ev(EV_RETRY, XF_POSTED, DIR_DOWN, BUS_SEC, 1'b0, 1'b0, 1'b1, "R2 drop pulses without assert");

        // R3 forwarding disabled
        c_serr = 1'b1;
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R11 clear received");
        c_fwd = 1'b0;
        cyc(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 forward disabled");
        idle("R12 final idle");
        idle("R12 final idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule